// File: doc/BRIEF.md
# SPI Baud Divider Encoder

This block turns a requested integer clock divider into the packed prescaler byte of a serial peripheral clock generator. The prescaler divides the core clock by a 4-bit rate value (`spr`) times a power of two given by a 3-bit exponent (`sppr`). The encoder picks the smallest divisor of that form that is not below the request, so the resulting serial clock never runs faster than asked.

A request arrives on a valid/ready handshake with a 16-bit divider and an optional minimum divider that stands for a bus speed ceiling. The response returns the packed byte, the divisor actually achieved and an error flag. The error flag is set when no encodable divisor is large enough. Only one request is processed at a time. The response appears one cycle after the request is accepted.

Top module: `baud_div_enc`

## Requirements
- R1: After reset `req_ready` is 1 and `rsp_valid` is 0.
- R2: An effective divider below 16 is encoded with `spr` equal to the divider and `sppr` = 0, and the achieved divisor equals the divider.
- R3: For an effective divider of 16 or more, the achieved divisor is the smallest value `spr << sppr` (with `spr` < 16 and `sppr` ≤ 7) that is at least the divider. `sppr` is the smallest exponent that can express that value, so whenever `sppr` > 0, bit 3 of `spr` is 1.
- R4: When rounding up carries the leading one to a higher bit, the exponent is raised and the rate is renormalised. For example, 31 gives `spr`=8, `sppr`=2, divisor 32 and byte 0x48.
- R5: An effective divider above 1920 cannot be encoded. It is answered with `rsp_err`=1, `rsp_cfg`=0 and `rsp_divisor`=0.
- R6: Byte layout: bits 7:6 = `sppr[2:1]`, bit 5 = 0, bit 4 = `sppr[0]`, bits 3:0 = `spr`. The achieved divisor equals `rsp_cfg[3:0] << {rsp_cfg[7:6], rsp_cfg[4]}`.
- R7: A nonzero `req_min` raises a smaller request to `req_min` before encoding. A `req_min` of 0 leaves the request unchanged.
- R8: A divider of 0 is treated as 1.
- R9: `req_ready` falls on acceptance and stays 0 until the response handshake. `rsp_valid` rises in the cycle after acceptance. The response fields stay stable while `rsp_valid` is 1 and `rsp_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Encoder idle, request accepted when valid |
| req_div | input | 16 | Requested divider |
| req_min | input | 16 | Minimum divider, 0 for none |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed when valid |
| rsp_cfg | output | 8 | Packed prescaler byte |
| rsp_divisor | output | 16 | Achieved divisor, 0 on error |
| rsp_err | output | 1 | Divider not encodable |

## Verification
The embedded assertions check the following on every cycle:
- the handshake rules: ready stays low while a response is pending, and a stalled response holds its fields;
- that a successful divisor is never below the clamped request;
- that the byte decodes back to the reported divisor;
- that bit 5 is always zero;
- that a nonzero exponent comes with a normalised rate.

Minimality of the chosen divisor, the renormalisation corner, the error threshold at 1920/1921, the zero-divider and minimum-clamp rules can only be shown by the bench. The bench compares each response against an exhaustive search for the smallest encodable value.

// File: rtl/baud_div_enc.sv
module baud_div_enc #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [DW-1:0] req_div,
  input  logic [DW-1:0] req_min,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [7:0]    rsp_cfg,
  output logic [DW-1:0] rsp_divisor,
  output logic          rsp_err
);

  localparam int RW = DW + 1;

  logic          busy, vld;
  logic [DW-1:0] eff_q;
  logic [DW-1:0] d_nz, eff_in;
  logic [4:0]    f1, f2, s1, s2;
  logic [RW-1:0] mask, rnd;
  logic [3:0]    spr_w;
  logic          err_w;

  assign d_nz      = (req_div == '0) ? DW'(1) : req_div;
  assign eff_in    = (req_min != '0 && d_nz < req_min) ? req_min : d_nz;
  assign req_ready = !busy;
  assign rsp_valid = vld;

  always_comb begin
    f1 = '0;
    for (int i = 0; i < DW; i++) if (eff_q[i]) f1 = 5'(i + 1);
    s1   = (f1 > 5'd4) ? f1 - 5'd4 : 5'd0;
    mask = (RW'(1) << s1) - RW'(1);
    rnd  = ({1'b0, eff_q} + mask) & ~mask;
    f2 = '0;
    for (int i = 0; i < RW; i++) if (rnd[i]) f2 = 5'(i + 1);
    s2    = (f2 > 5'd4) ? f2 - 5'd4 : 5'd0;
    spr_w = 4'(rnd >> s2);
    err_w = s2 > 5'd7;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      vld         <= 1'b0;
      eff_q       <= '0;
      rsp_cfg     <= '0;
      rsp_divisor <= '0;
      rsp_err     <= 1'b0;
    end else begin
      if (!busy && req_valid) begin
        busy  <= 1'b1;
        eff_q <= eff_in;
      end
      if (busy && !vld) begin
        vld         <= 1'b1;
        rsp_err     <= err_w;
        rsp_cfg     <= err_w ? 8'h00 : {s2[2:1], 1'b0, s2[0], spr_w};
        rsp_divisor <= err_w ? '0 : rnd[DW-1:0];
      end
      if (vld && rsp_ready) begin
        vld  <= 1'b0;
        busy <= 1'b0;
      end
    end
  end

  // R9
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R9
  hold_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_cfg) && $stable(rsp_divisor) && $stable(rsp_err)));

  // R3
  not_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_err) |-> (rsp_divisor >= eff_q));

  // R6
  decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_err) |-> (rsp_divisor == (DW'(rsp_cfg[3:0]) << {rsp_cfg[7:6], rsp_cfg[4]})));

  // R6
  bit5_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !rsp_cfg[5]);

  // R3
  norm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_err && {rsp_cfg[7:6], rsp_cfg[4]} != 3'd0) |-> rsp_cfg[3]);

endmodule

// File: tb/tb_baud_div_enc.sv
module tb_baud_div_enc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [15:0] req_div = '0;
  logic [15:0] req_min = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [7:0]  rsp_cfg;
  logic [15:0] rsp_divisor;
  logic        rsp_err;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  baud_div_enc dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_div(req_div), .req_min(req_min), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_cfg(rsp_cfg), .rsp_divisor(rsp_divisor),
    .rsp_err(rsp_err)
  );

  int    exp_cfg, exp_div, exp_err;
  string exp_tag;
  bit    m_busy = 0, m_pend = 0, m_valid = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // Search for the smallest encodable divisor not below eff.
  task automatic ref_enc(input int eff);
    exp_err = 1; exp_cfg = 0; exp_div = 0;
    for (int v = eff; v <= 1920; v++) begin
      for (int s = 0; s < 8; s++) begin
        if (exp_err && (v % (1 << s)) == 0 && (v >> s) <= 15) begin
          exp_err = 0;
          exp_div = v;
          exp_cfg = ((s >> 1) << 6) | ((s & 1) << 4) | (v >> s);
        end
      end
      if (!exp_err) break;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy <= 0; m_pend <= 0; m_valid <= 0;
    end else begin
      if (m_valid && rsp_ready) begin m_valid <= 0; m_busy <= 0; end
      if (!m_busy && req_valid) begin m_busy <= 1; m_pend <= 1; end
      if (m_pend) begin m_pend <= 0; m_valid <= 1; end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(req_ready == !m_busy, "R9 ready", req_ready, !m_busy);
      chk(rsp_valid == m_valid, "R9 valid", rsp_valid, m_valid);
      if (rsp_valid && m_valid) begin
        chk(rsp_err == exp_err, {exp_tag, " err"}, rsp_err, exp_err);
        chk(rsp_cfg == exp_cfg, {exp_tag, " cfg"}, rsp_cfg, exp_cfg);
        chk(rsp_divisor == exp_div, {exp_tag, " divisor"}, rsp_divisor, exp_div);
      end
    end
  end

  task automatic send(input int d, input int mn, input string tag, input int stall);
    int eff;
    eff = (d == 0) ? 1 : d;
    if (mn != 0 && eff < mn) eff = mn;
    ref_enc(eff);
    exp_tag = tag;
    @(negedge clk);
    req_valid = 1'b1; req_div = 16'(d); req_min = 16'(mn);
    @(negedge clk);
    req_valid = 1'b0; req_div = 16'hFFFF; req_min = 16'h0;
    repeat (stall + 1) @(negedge clk);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1 valid", rsp_valid, 0);
    rst_n = 1'b1;
    send(0, 0, "R8 zero", 0);
    send(1, 0, "R2 one", 1);
    send(7, 0, "R7 zero-min", 0);
    send(15, 0, "R2 fifteen", 2);
    send(16, 0, "R3 sixteen", 0);
    send(17, 0, "R3 seventeen", 0);
    send(31, 0, "R4 renorm", 3);
    send(255, 0, "R4 renorm255", 0);
    send(100, 0, "R3 hundred", 0);
    send(1920, 0, "R6 max", 0);
    send(1921, 0, "R5 over", 0);
    send(65535, 0, "R5 top", 4);
    send(5, 40, "R7 clamp", 0);
    send(50, 40, "R7 above-min", 0);
    send(0, 3000, "R5 clamp-err", 0);
    for (int d = 0; d < 2100; d += 7) send(d, 0, "R3 sweep", d % 3);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule